// File: doc/BRIEF.md
# Multi-Level Daisy-Chained Bus Arbiter

This block is a centralized arbiter for a shared bus whose masters are grouped into priority tiers. Every tier has one request line, which is the OR of the requests of the masters in that tier, and one grant line, which enters the first slot of that tier and passes from slot to slot. A slot that is requesting when the grant reaches it keeps the grant and blocks it from the slots further down. Priority therefore follows the tier first and the chain position second. Tier 0 is the most urgent, and slot 0 is nearest the arbiter within each tier.

The slot that wins becomes bus owner and raises the shared acknowledge line. It holds acknowledge for its whole tenure, so the arbiter can drop the grant at once. Other masters may raise requests while the bus is busy. The arbiter issues the next grant only after acknowledge has fallen. The host processor is wired in as one extra slot that sits below every tier, so it wins only when no tier is requesting.

The controller has three states. In `ST_IDLE` the bus is free and no grant is out. In `ST_OFFER` exactly one grant line is high for one cycle. In `ST_HELD` an owner holds the bus. The transitions are:
- `ST_IDLE -> ST_OFFER` when any request is present and acknowledge is low.
- `ST_OFFER -> ST_HELD` when a slot takes the grant.
- `ST_OFFER -> ST_IDLE` when no slot takes it.
- `ST_HELD -> ST_OFFER` when acknowledge is low and requests are pending.
- `ST_HELD -> ST_IDLE` when acknowledge is low and nothing is pending.

Top module: `mlevel_bus_arbiter`

## Requirements
- R1: `tier_req[t]` is the combinational OR of `dev_req[t*DEVS +: DEVS]`.
- R2: When the arbiter makes its decision, the grant goes to the lowest-numbered tier that is requesting.
- R3: Within the granted tier, the lowest-indexed requesting slot takes the grant. Slot j of tier t is bit t*DEVS+j of `dev_req` and `owner_vec`.
- R4: Timing of a grant:
  - If a request is present at a clock edge while the bus is idle, one grant line is high for exactly one cycle after that edge.
  - At the next edge the taker appears in `owner_vec` (or `host_owner`) and `bus_ack` rises.
  - All grant lines are low from that point on.
- R5: Requests raised while the bus is owned show on `tier_req` and are served after the owner releases the bus.
- R6: `host_gnt` is issued only when no tier was requesting at the decision edge.
- R7: No grant line is high while `bus_ack` is high. A decision is taken no earlier than the edge after `bus_ack` falls.
- R8: The owner holds `bus_ack` until the edge at which `xfer_last` is sampled high. After that edge `bus_ack` is low.
- R9: At most one grant line is high at any time, and at most one slot owns the bus.
- R10: After reset, all grant lines, `bus_ack`, `owner_vec` and `host_owner` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_req | input | TIERS*DEVS | Per-slot bus requests, tier-major |
| host_req | input | 1 | Host processor request (lowest priority) |
| xfer_last | input | 1 | Current owner is in its final transfer cycle |
| tier_req | output | TIERS | OR of the requests in each tier |
| tier_gnt | output | TIERS | Grant line entering each tier's chain |
| host_gnt | output | 1 | Grant to the host slot |
| owner_vec | output | TIERS*DEVS | One-hot current owner among device slots |
| host_owner | output | 1 | Host slot owns the bus |
| bus_ack | output | 1 | Acknowledge: bus is held by an owner |

## Verification
The hardest situation to reach is a higher-priority request that arrives during a tenure. It has to stay pending while acknowledge is high, and then win in the first cycle after release against requests that were already waiting. The bench reaches it by raising a tier-0 request only after a lower tier has taken ownership. It then holds that tenure for several cycles, checking the request line and the silent grant lines each cycle. Finally it ends the tenure with `xfer_last` and checks the cycle at which the pending winner is granted.

// File: rtl/marb_pkg.sv
package marb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_OFFER = 2'd1,
        ST_HELD  = 2'd2
    } arb_state_e;
endpackage

// File: rtl/marb_chain.sv
// One daisy chain of device slots sharing a request line and a grant line.
module marb_chain #(
    parameter int DEVS = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DEVS-1:0] req,
    input  logic            gnt_in,
    input  logic            xfer_last,
    output logic            line_req,
    output logic [DEVS-1:0] owner,
    output logic            held,
    output logic            taken
);
    logic [DEVS-1:0] pass;
    logic [DEVS-1:0] take;
    logic [DEVS-1:0] owner_q;

    assign pass[0] = gnt_in;

    // the grant ripples past idle slots and stops at the first requester
    for (genvar j = 0; j < DEVS; j++) begin : g_slot
        assign take[j] = pass[j] & req[j];
        if (j < DEVS - 1) begin : g_fwd
            assign pass[j+1] = pass[j] & ~req[j];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q <= '0;
        end else if ((|owner_q) && xfer_last) begin
            owner_q <= '0;
        end else if (|take) begin
            owner_q <= take;
        end
    end

    assign line_req = |req;
    assign owner    = owner_q;
    assign held     = |owner_q;
    assign taken    = |take;

    AST_ONE_OWNER_IN_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(owner_q)); // R9
    AST_OWNER_WAS_OFFERED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(held) |-> $past(gnt_in)); // R4
endmodule

// File: rtl/marb_ctrl.sv
// Central arbitration state machine: picks a tier and drives its grant line.
module marb_ctrl
    import marb_pkg::*;
#(
    parameter int TIERS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TIERS-1:0] tier_req,
    input  logic             host_req,
    input  logic             bus_ack,
    input  logic             any_taken,
    output logic [TIERS-1:0] tier_gnt,
    output logic             host_gnt
);
    localparam int SELW = $clog2(TIERS + 1);
    localparam logic [SELW-1:0] HOST_SEL = SELW'(TIERS);

    arb_state_e      state_q, state_d;
    logic [SELW-1:0] sel_q, pick;
    logic            pick_vld;
    logic            load_sel;

    // fixed priority: lowest tier index first, host slot last
    always_comb begin
        pick     = HOST_SEL;
        pick_vld = host_req | (|tier_req);
        for (int t = TIERS - 1; t >= 0; t--) begin
            if (tier_req[t]) pick = SELW'(t);
        end
    end

    always_comb begin
        state_d  = state_q;
        load_sel = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (pick_vld && !bus_ack) begin
                    state_d  = ST_OFFER;
                    load_sel = 1'b1;
                end
            end
            ST_OFFER: begin
                state_d = any_taken ? ST_HELD : ST_IDLE;
            end
            ST_HELD: begin
                if (!bus_ack) begin
                    if (pick_vld) begin
                        state_d  = ST_OFFER;
                        load_sel = 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sel_q   <= '0;
        end else begin
            state_q <= state_d;
            if (load_sel) sel_q <= pick;
        end
    end

    for (genvar t = 0; t < TIERS; t++) begin : g_gnt
        assign tier_gnt[t] = (state_q == ST_OFFER) && (sel_q == SELW'(t));
    end
    assign host_gnt = (state_q == ST_OFFER) && (sel_q == HOST_SEL);

    AST_NO_GNT_WHILE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (host_gnt || (|tier_gnt)) |-> !bus_ack); // R7
    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({host_gnt, tier_gnt})); // R9
    AST_GNT_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (host_gnt || (|tier_gnt)) |=> !(host_gnt || (|tier_gnt))); // R4
    AST_HOST_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_gnt) |-> ($past(tier_req) == '0)); // R6
endmodule

// File: rtl/mlevel_bus_arbiter.sv
module mlevel_bus_arbiter #(
    parameter int TIERS = 4,
    parameter int DEVS  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [TIERS*DEVS-1:0] dev_req,
    input  logic                  host_req,
    input  logic                  xfer_last,
    output logic [TIERS-1:0]      tier_req,
    output logic [TIERS-1:0]      tier_gnt,
    output logic                  host_gnt,
    output logic [TIERS*DEVS-1:0] owner_vec,
    output logic                  host_owner,
    output logic                  bus_ack
);
    logic [TIERS-1:0] tier_held;
    logic [TIERS-1:0] tier_taken;
    logic             host_held, host_taken, host_line;

    for (genvar t = 0; t < TIERS; t++) begin : g_tier
        marb_chain #(.DEVS(DEVS)) u_chain (
            .clk      (clk),
            .rst_n    (rst_n),
            .req      (dev_req[t*DEVS +: DEVS]),
            .gnt_in   (tier_gnt[t]),
            .xfer_last(xfer_last),
            .line_req (tier_req[t]),
            .owner    (owner_vec[t*DEVS +: DEVS]),
            .held     (tier_held[t]),
            .taken    (tier_taken[t])
        );
    end

    marb_chain #(.DEVS(1)) u_host (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (host_req),
        .gnt_in   (host_gnt),
        .xfer_last(xfer_last),
        .line_req (host_line),
        .owner    (host_owner),
        .held     (host_held),
        .taken    (host_taken)
    );

    assign bus_ack = host_held | (|tier_held);

    marb_ctrl #(.TIERS(TIERS)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .tier_req (tier_req),
        .host_req (host_line),
        .bus_ack  (bus_ack),
        .any_taken(host_taken | (|tier_taken)),
        .tier_gnt (tier_gnt),
        .host_gnt (host_gnt)
    );

    AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack && !xfer_last) |=> bus_ack); // R8
    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack && xfer_last) |=> !bus_ack); // R8
    AST_SINGLE_BUS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({host_owner, owner_vec})); // R9
endmodule

// File: tb/mlevel_bus_arbiter_bench.sv
module mlevel_bus_arbiter_bench;
    localparam int TIERS = 4;
    localparam int DEVS  = 4;
    localparam int N     = TIERS * DEVS;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N-1:0]     dev_req = '0;
    logic             host_req = 1'b0;
    logic             xfer_last = 1'b0;
    logic [TIERS-1:0] tier_req, tier_gnt;
    logic             host_gnt, host_owner, bus_ack;
    logic [N-1:0]     owner_vec;

    int tests = 0;
    int failed = 0;
    bit done = 0;

    always #5 clk = ~clk;

    mlevel_bus_arbiter #(.TIERS(TIERS), .DEVS(DEVS)) u_mlevel_bus_arbiter (
        .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .host_req(host_req),
        .xfer_last(xfer_last), .tier_req(tier_req), .tier_gnt(tier_gnt),
        .host_gnt(host_gnt), .owner_vec(owner_vec), .host_owner(host_owner),
        .bus_ack(bus_ack)
    );

    task automatic chk(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            failed++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // spec model: lowest slot index wins (tier-major order), host last
    function automatic int exp_winner();
        for (int i = 0; i < N; i++) if (dev_req[i]) return i;
        if (host_req) return N;
        return -1;
    endfunction

    // serve the expected winner through one full tenure
    task automatic serve_one(string tag);
        int w;
        w = exp_winner();
        @(negedge clk);
        if (w == N) begin
            chk({tag, " R6 host grant"}, int'(host_gnt), 1);
            chk({tag, " R6 tier grants idle"}, int'(tier_gnt), 0);
        end else begin
            chk({tag, " R2 tier grant"}, int'(tier_gnt), 1 << (w / DEVS));
            chk({tag, " R9 host grant idle"}, int'(host_gnt), 0);
        end
        @(negedge clk);
        if (w == N) begin
            chk({tag, " R4 host owner"}, int'(host_owner), 1);
            host_req = 1'b0;
        end else begin
            chk({tag, " R3 owner slot"}, int'(owner_vec), 1 << w);
            dev_req[w] = 1'b0;
        end
        chk({tag, " R4 ack up"}, int'(bus_ack), 1);
        chk({tag, " R4 grant dropped"}, int'({host_gnt, tier_gnt}), 0);
        @(negedge clk);
        chk({tag, " R8 ack held"}, int'(bus_ack), 1);
        xfer_last = 1'b1;
        @(negedge clk);
        xfer_last = 1'b0;
        chk({tag, " R8 ack released"}, int'(bus_ack), 0);
        chk({tag, " R8 owner cleared"}, int'({host_owner, owner_vec}), 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R10 grants", int'({host_gnt, tier_gnt}), 0);
        chk("R10 ack", int'(bus_ack), 0);
        chk("R10 owners", int'({host_owner, owner_vec}), 0);
    endtask

    task automatic t_single();
        dev_req[11] = 1'b1;
        #1 chk("R1 single tier line", int'(tier_req), 4'b0100);
        serve_one("single");
    endtask

    task automatic t_tiers();
        dev_req[6]  = 1'b1;
        dev_req[12] = 1'b1;
        #1 chk("R1 two tier lines", int'(tier_req), 4'b1010);
        serve_one("tier1 first");
        serve_one("tier3 second");
    endtask

    task automatic t_chain();
        dev_req[9]  = 1'b1;
        dev_req[11] = 1'b1;
        #1 chk("R1 shared line", int'(tier_req), 4'b0100);
        serve_one("chain near");
        serve_one("chain far");
    endtask

    task automatic t_host();
        host_req    = 1'b1;
        dev_req[15] = 1'b1;
        serve_one("device before host");
        serve_one("host after device");
        host_req = 1'b1;
        serve_one("host alone");
    endtask

    task automatic t_overlap();
        dev_req[13] = 1'b1;
        @(negedge clk);
        chk("R4 tier3 grant", int'(tier_gnt), 4'b1000);
        @(negedge clk);
        chk("R4 owner", int'(owner_vec), 1 << 13);
        dev_req[13] = 1'b0;
        dev_req[1]  = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R5 posted request visible", int'(tier_req), 4'b0001);
            chk("R7 no grant while owned", int'({host_gnt, tier_gnt}), 0);
        end
        xfer_last = 1'b1;
        @(negedge clk);
        xfer_last = 1'b0;
        chk("R7 no grant on release cycle", int'({host_gnt, tier_gnt}), 0);
        chk("R8 ack low", int'(bus_ack), 0);
        serve_one("R5 pending served");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_tiers();
        t_chain();
        t_host();
        t_overlap();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, failed);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++;
            failed++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, failed);
            $finish;
        end
    end
endmodule